// File: doc/BRIEF.md
# Paired-Page Translation Buffer with Access-Rights Check

This block is a small fully associative translation buffer. Every entry maps two neighbouring virtual pages, an even one and an odd one, that share a single tag. The tag is made of a virtual page-pair number, an address-space identifier and a page-size mask. Each half has its own page frame number, valid, dirty and cache-attribute bits. Each half also has two protection bits: one blocks data reads and one blocks instruction fetch.

Software-side logic writes an entry through an index port, supplying the tag and two 32-bit half-entry images. It reads the entry back through the same images. A lookup supplies a virtual address, the current address-space identifier and an access kind: fetch, load, store, or load relative to the program counter. One cycle later the block returns either a physical address or a single fault code. When more than one condition applies, the fault codes are ranked in a fixed priority.

Top module: `pair_tlb`

## Requirements
- R1: An entry hits when the virtual address bits above the pair (bit 13 up, with bits covered by the entry's mask ignored) equal its tag, and either its identifier equals the lookup identifier or its global flag is set. When no entry hits, the fault is 1 (no match).
- R2: The half is chosen by the virtual address bit just above the page offset, bit 12+2k for a page of 4 KiB·4^k. A 0 in that bit selects the even image and a 1 selects the odd image.
- R3: A successful lookup returns fault 0. The physical address is the selected frame number shifted left by 12, ORed with the address bits below the half-select bit. Results appear on the outputs one clock after the request, with a done strobe.
- R4: Validity is checked first. If the selected half's valid bit (image bit 1) is clear, the fault is 2 (invalid), whatever the access kind or the protection bits.
- R5: A fetch (kind 0) faults with 5 (execute-inhibit) when the half's bit 30 is set. A fetch ignores bit 31 and the dirty bit.
- R6: A load (kind 1) faults with 4 (read-inhibit) when the half's bit 31 is set. A load ignores bit 30 and the dirty bit.
- R7: A load relative to the program counter (kind 3) faults with 4 only when bit 31 and bit 30 are both set. If bit 30 is clear, the load succeeds even with bit 31 set.
- R8: A store (kind 2) faults with 3 (modified) when the dirty bit (image bit 2) is clear. A store ignores bits 30 and 31.
- R9: Whenever the fault is non-zero, the physical address output is zero.
- R10: The entry's global flag is the AND of bit 0 of both images at write time. The flag reads back in bit 0 of both images.
- R11: Reading an entry returns, one clock after the index is presented, the tag, identifier, mask and both images. The image layout is bit 0 global, bit 1 valid, bit 2 dirty, bits 5:3 attribute, bits 25:6 frame, bit 30 execute-inhibit and bit 31 read-inhibit. Bits 29:26 read as zero.
- R12: If several entries hit, the one with the lowest index supplies the result.
- R13: Reset clears every entry to all-zero fields and clears all outputs. A lookup of address 0 with identifier 0 then faults with 2, and an address with a non-zero pair number faults with 1.
- R14: The mask field is 12 bits wide and covers address bits 24:13. Page sizes from 4 KiB to 16 MiB are written as mask values of 2k low ones, for k from 0 to 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write the entry at wr_idx this cycle |
| wr_idx | input | 4 | Entry index to write |
| wr_vpn2 | input | 19 | Page-pair number (address bits 31:13) |
| wr_asid | input | 8 | Address-space identifier |
| wr_mask | input | 12 | Page-size mask over address bits 24:13 |
| wr_lo0 | input | 32 | Even-half image |
| wr_lo1 | input | 32 | Odd-half image |
| rd_idx | input | 4 | Entry index to read back |
| rd_vpn2 | output | 19 | Read-back page-pair number |
| rd_asid | output | 8 | Read-back identifier |
| rd_mask | output | 12 | Read-back mask |
| rd_lo0 | output | 32 | Read-back even image |
| rd_lo1 | output | 32 | Read-back odd image |
| lk_req | input | 1 | Lookup request |
| lk_va | input | 32 | Virtual address |
| lk_asid | input | 8 | Current identifier |
| lk_kind | input | 2 | 0 fetch, 1 load, 2 store, 3 load relative to the program counter |
| lk_done | output | 1 | Result valid |
| lk_fault | output | 3 | 0 ok, 1 no match, 2 invalid, 3 modified, 4 read-inhibit, 5 execute-inhibit |
| lk_pa | output | 32 | Physical address |

## Verification
Several properties are checked on every cycle. A zero address accompanies every fault. Each access kind may only raise the faults that belong to it. A no-match result agrees with the hit vector. The selected hit is the lowest-indexed one. A write's global flag is the AND of both images. Only the bench scenarios can show the exact frame arithmetic, the half selection for each page size, the order among the valid, execute, read and dirty checks, and the exemption for loads relative to the program counter. They also show the read-back layout, and they compare lookups against an independent model of the entry array.

// File: rtl/pair_tlb_pkg.sv
package pair_tlb_pkg;

  typedef enum logic [1:0] {
    ACC_FETCH  = 2'd0,
    ACC_LOAD   = 2'd1,
    ACC_STORE  = 2'd2,
    ACC_PCLOAD = 2'd3
  } acc_e;

  typedef enum logic [2:0] {
    FLT_NONE     = 3'd0,
    FLT_NOMATCH  = 3'd1,
    FLT_INVALID  = 3'd2,
    FLT_MODIFIED = 3'd3,
    FLT_RDINH    = 3'd4,
    FLT_EXINH    = 3'd5
  } flt_e;

  // half-entry image positions (software-visible)
  localparam int LO_W   = 32;
  localparam int LO_G   = 0;
  localparam int LO_V   = 1;
  localparam int LO_D   = 2;
  localparam int LO_C   = 3;
  localparam int LO_PFN = 6;
  localparam int LO_XI  = 30;
  localparam int LO_RI  = 31;

  // internal packed half layout: {pfn, ri, xi, c[2:0], d, v}
  localparam int HF_V   = 0;
  localparam int HF_D   = 1;
  localparam int HF_C   = 2;
  localparam int HF_XI  = 5;
  localparam int HF_RI  = 6;
  localparam int HF_PFN = 7;

  localparam int PAGE_SH = 12;
  localparam int PAIR_SH = 13;

endpackage

// File: rtl/pair_tlb_store.sv
module pair_tlb_store
  import pair_tlb_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 19,
  parameter int ASID_W  = 8,
  parameter int MASK_W  = 12,
  parameter int PFN_W   = 20,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int HALF_W = HF_PFN + PFN_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [VPN_W-1:0]  wr_vpn2,
  input  logic [ASID_W-1:0] wr_asid,
  input  logic [MASK_W-1:0] wr_mask,
  input  logic [LO_W-1:0]   wr_lo0,
  input  logic [LO_W-1:0]   wr_lo1,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [VPN_W-1:0]  rd_vpn2,
  output logic [ASID_W-1:0] rd_asid,
  output logic [MASK_W-1:0] rd_mask,
  output logic [LO_W-1:0]   rd_lo0,
  output logic [LO_W-1:0]   rd_lo1,
  output logic [VPN_W-1:0]  e_vpn2  [ENTRIES],
  output logic [ASID_W-1:0] e_asid  [ENTRIES],
  output logic [MASK_W-1:0] e_mask  [ENTRIES],
  output logic              e_g     [ENTRIES],
  output logic [HALF_W-1:0] e_half0 [ENTRIES],
  output logic [HALF_W-1:0] e_half1 [ENTRIES]
);

  function automatic logic [HALF_W-1:0] unpack_lo(input logic [LO_W-1:0] lo);
    logic [HALF_W-1:0] h;
    h = '0;
    h[HF_V]            = lo[LO_V];
    h[HF_D]            = lo[LO_D];
    h[HF_C +: 3]       = lo[LO_C +: 3];
    h[HF_XI]           = lo[LO_XI];
    h[HF_RI]           = lo[LO_RI];
    h[HF_PFN +: PFN_W] = lo[LO_PFN +: PFN_W];
    return h;
  endfunction

  function automatic logic [LO_W-1:0] pack_lo(input logic [HALF_W-1:0] h, input logic g);
    logic [LO_W-1:0] lo;
    lo = '0;
    lo[LO_G]            = g;
    lo[LO_V]            = h[HF_V];
    lo[LO_D]            = h[HF_D];
    lo[LO_C +: 3]       = h[HF_C +: 3];
    lo[LO_XI]           = h[HF_XI];
    lo[LO_RI]           = h[HF_RI];
    lo[LO_PFN +: PFN_W] = h[HF_PFN +: PFN_W];
    return lo;
  endfunction

  // spare image bits between frame and protection bits are not stored
  logic unused_spare;
  if (LO_PFN + PFN_W < LO_XI) begin : g_spare
    assign unused_spare = ^{wr_lo0[LO_XI-1:LO_PFN+PFN_W], wr_lo1[LO_XI-1:LO_PFN+PFN_W]};
  end else begin : g_nospare
    assign unused_spare = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < ENTRIES; i++) begin
        e_vpn2[i]  <= '0;
        e_asid[i]  <= '0;
        e_mask[i]  <= '0;
        e_g[i]     <= 1'b0;
        e_half0[i] <= '0;
        e_half1[i] <= '0;
      end
      rd_vpn2 <= '0;
      rd_asid <= '0;
      rd_mask <= '0;
      rd_lo0  <= '0;
      rd_lo1  <= '0;
    end else begin
      if (wr_en) begin
        e_vpn2[wr_idx]  <= wr_vpn2;
        e_asid[wr_idx]  <= wr_asid;
        e_mask[wr_idx]  <= wr_mask;
        e_g[wr_idx]     <= wr_lo0[LO_G] & wr_lo1[LO_G];
        e_half0[wr_idx] <= unpack_lo(wr_lo0);
        e_half1[wr_idx] <= unpack_lo(wr_lo1);
      end
      rd_vpn2 <= e_vpn2[rd_idx];
      rd_asid <= e_asid[rd_idx];
      rd_mask <= e_mask[rd_idx];
      rd_lo0  <= pack_lo(e_half0[rd_idx], e_g[rd_idx]);
      rd_lo1  <= pack_lo(e_half1[rd_idx], e_g[rd_idx]);
    end
  end

  // R10: global flag of a freshly written entry is the AND of both image G bits
  a_r10_global_and: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(wr_en)) |->
      (e_g[$past(wr_idx)] == ($past(wr_lo0[LO_G]) & $past(wr_lo1[LO_G]))));

endmodule

// File: rtl/pair_tlb_match.sv
module pair_tlb_match
  import pair_tlb_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 19,
  parameter int ASID_W  = 8,
  parameter int MASK_W  = 12,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [VPN_W-1:0]  va_vpn2,
  input  logic [ASID_W-1:0] asid,
  input  logic [VPN_W-1:0]  e_vpn2 [ENTRIES],
  input  logic [ASID_W-1:0] e_asid [ENTRIES],
  input  logic [MASK_W-1:0] e_mask [ENTRIES],
  input  logic              e_g    [ENTRIES],
  output logic              any_hit,
  output logic [IDX_W-1:0]  hit_idx
);

  logic [ENTRIES-1:0] hits;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    logic [VPN_W-1:0] ign;
    logic             tag_eq;
    logic             id_ok;
    assign ign    = VPN_W'(e_mask[i]);
    assign tag_eq = ((va_vpn2 ^ e_vpn2[i]) & ~ign) == '0;
    assign id_ok  = e_g[i] | (e_asid[i] == asid);
    assign hits[i] = tag_eq & id_ok;
  end

  always_comb begin
    any_hit = |hits;
    hit_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (hits[i]) hit_idx = IDX_W'(i);
    end
  end

  // R12: chosen entry hits and no lower-indexed entry does
  a_r12_lowest_index: assert property (@(posedge clk) disable iff (rst)
    any_hit |-> (hits[hit_idx] &&
                 ((hits & ((ENTRIES'(1) << hit_idx) - ENTRIES'(1))) == '0)));

endmodule

// File: rtl/pair_tlb_rights.sv
module pair_tlb_rights
  import pair_tlb_pkg::*;
#(
  parameter int VA_W   = 32,
  parameter int MASK_W = 12,
  parameter int PFN_W  = 20,
  localparam int PA_W   = PFN_W + PAGE_SH,
  localparam int HALF_W = HF_PFN + PFN_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic [VA_W-1:0]   va,
  input  logic [1:0]        kind,
  input  logic              any_hit,
  input  logic [MASK_W-1:0] mask,
  input  logic [HALF_W-1:0] half0,
  input  logic [HALF_W-1:0] half1,
  output logic              done,
  output logic [2:0]        fault,
  output logic [PA_W-1:0]   pa
);

  logic [VA_W-1:0]   span;
  logic              odd;
  logic [HALF_W-1:0] h;
  logic [VA_W-1:0]   offs;
  flt_e              flt_c;
  logic [PA_W-1:0]   pa_c;
  logic              unused_attr;

  assign unused_attr = ^h[HF_C +: 3];

  always_comb begin
    span  = VA_W'({mask, {PAIR_SH{1'b1}}});
    odd   = |(va & span & ~(span >> 1));
    h     = odd ? half1 : half0;
    offs  = va & (span >> 1);

    flt_c = FLT_NONE;
    if (!any_hit) begin
      flt_c = FLT_NOMATCH;
    end else if (!h[HF_V]) begin
      flt_c = FLT_INVALID;
    end else begin
      unique case (acc_e'(kind))
        ACC_FETCH:  if (h[HF_XI])             flt_c = FLT_EXINH;
        ACC_LOAD:   if (h[HF_RI])             flt_c = FLT_RDINH;
        ACC_PCLOAD: if (h[HF_RI] && h[HF_XI]) flt_c = FLT_RDINH;
        ACC_STORE:  if (!h[HF_D])             flt_c = FLT_MODIFIED;
        default:    flt_c = FLT_NONE;
      endcase
    end

    if (flt_c == FLT_NONE) pa_c = {h[HF_PFN +: PFN_W], {PAGE_SH{1'b0}}} | PA_W'(offs);
    else                   pa_c = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      done  <= 1'b0;
      fault <= '0;
      pa    <= '0;
    end else begin
      done  <= req;
      fault <= req ? flt_c : 3'd0;
      pa    <= req ? pa_c : '0;
    end
  end

  // R9: no address leaks out with a fault
  a_r9_pa_zero_on_fault: assert property (@(posedge clk) disable iff (rst)
    (done && fault != 3'd0) |-> (pa == '0));

  // R5: a fetch never reports read-inhibit or modified
  a_r5_fetch_faults: assert property (@(posedge clk) disable iff (rst)
    (done && $past(kind) == 2'd0) |-> (fault != 3'd4 && fault != 3'd3));

  // R6: a load never reports execute-inhibit or modified
  a_r6_load_faults: assert property (@(posedge clk) disable iff (rst)
    (done && $past(kind) == 2'd1) |-> (fault != 3'd5 && fault != 3'd3));

  // R8: a store never reports an inhibit fault
  a_r8_store_faults: assert property (@(posedge clk) disable iff (rst)
    (done && $past(kind) == 2'd2) |-> (fault != 3'd4 && fault != 3'd5));

  // R7: a relative load never reports execute-inhibit or modified
  a_r7_pcload_faults: assert property (@(posedge clk) disable iff (rst)
    (done && $past(kind) == 2'd3) |-> (fault != 3'd5 && fault != 3'd3));

  // R1: no-match reported exactly when the hit vector was empty
  a_r1_nomatch_agrees: assert property (@(posedge clk) disable iff (rst)
    done |-> ((fault == 3'd1) == !$past(any_hit)));

endmodule

// File: rtl/pair_tlb.sv
module pair_tlb
  import pair_tlb_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int VA_W    = 32,
  parameter int PA_W    = 32,
  parameter int ASID_W  = 8,
  parameter int MASK_W  = 12,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int VPN_W  = VA_W - PAIR_SH,
  localparam int PFN_W  = PA_W - PAGE_SH,
  localparam int HALF_W = HF_PFN + PFN_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [VPN_W-1:0]  wr_vpn2,
  input  logic [ASID_W-1:0] wr_asid,
  input  logic [MASK_W-1:0] wr_mask,
  input  logic [31:0]       wr_lo0,
  input  logic [31:0]       wr_lo1,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [VPN_W-1:0]  rd_vpn2,
  output logic [ASID_W-1:0] rd_asid,
  output logic [MASK_W-1:0] rd_mask,
  output logic [31:0]       rd_lo0,
  output logic [31:0]       rd_lo1,
  input  logic              lk_req,
  input  logic [VA_W-1:0]   lk_va,
  input  logic [ASID_W-1:0] lk_asid,
  input  logic [1:0]        lk_kind,
  output logic              lk_done,
  output logic [2:0]        lk_fault,
  output logic [PA_W-1:0]   lk_pa
);

  logic [VPN_W-1:0]  e_vpn2  [ENTRIES];
  logic [ASID_W-1:0] e_asid  [ENTRIES];
  logic [MASK_W-1:0] e_mask  [ENTRIES];
  logic              e_g     [ENTRIES];
  logic [HALF_W-1:0] e_half0 [ENTRIES];
  logic [HALF_W-1:0] e_half1 [ENTRIES];
  logic              any_hit;
  logic [IDX_W-1:0]  hit_idx;

  pair_tlb_store #(
    .ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W), .MASK_W(MASK_W), .PFN_W(PFN_W)
  ) u_store (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_vpn2(wr_vpn2), .wr_asid(wr_asid),
    .wr_mask(wr_mask), .wr_lo0(wr_lo0), .wr_lo1(wr_lo1),
    .rd_idx(rd_idx), .rd_vpn2(rd_vpn2), .rd_asid(rd_asid), .rd_mask(rd_mask),
    .rd_lo0(rd_lo0), .rd_lo1(rd_lo1),
    .e_vpn2(e_vpn2), .e_asid(e_asid), .e_mask(e_mask), .e_g(e_g),
    .e_half0(e_half0), .e_half1(e_half1)
  );

  pair_tlb_match #(
    .ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W), .MASK_W(MASK_W)
  ) u_match (
    .clk(clk), .rst(rst),
    .va_vpn2(lk_va[VA_W-1:PAIR_SH]), .asid(lk_asid),
    .e_vpn2(e_vpn2), .e_asid(e_asid), .e_mask(e_mask), .e_g(e_g),
    .any_hit(any_hit), .hit_idx(hit_idx)
  );

  pair_tlb_rights #(
    .VA_W(VA_W), .MASK_W(MASK_W), .PFN_W(PFN_W)
  ) u_rights (
    .clk(clk), .rst(rst),
    .req(lk_req), .va(lk_va), .kind(lk_kind), .any_hit(any_hit),
    .mask(e_mask[hit_idx]), .half0(e_half0[hit_idx]), .half1(e_half1[hit_idx]),
    .done(lk_done), .fault(lk_fault), .pa(lk_pa)
  );

endmodule

// File: tb/pair_tlb_bench.sv
`timescale 1ns/1ps
module pair_tlb_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_idx = '0;
  logic [18:0] wr_vpn2 = '0;
  logic [7:0]  wr_asid = '0;
  logic [11:0] wr_mask = '0;
  logic [31:0] wr_lo0 = '0, wr_lo1 = '0;
  logic [3:0]  rd_idx = '0;
  logic [18:0] rd_vpn2;
  logic [7:0]  rd_asid;
  logic [11:0] rd_mask;
  logic [31:0] rd_lo0, rd_lo1;
  logic        lk_req = 1'b0;
  logic [31:0] lk_va = '0;
  logic [7:0]  lk_asid = '0;
  logic [1:0]  lk_kind = '0;
  logic        lk_done;
  logic [2:0]  lk_fault;
  logic [31:0] lk_pa;

  int n_chk = 0;
  int n_bad = 0;
  bit ended = 1'b0;

  // bench model of what was written
  logic [18:0] m_vpn [16];
  logic [7:0]  m_asid[16];
  int          m_k   [16];
  logic [31:0] m_lo0 [16];
  logic [31:0] m_lo1 [16];

  always #2.5 clk = ~clk;

  pair_tlb u_pair_tlb (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_vpn2(wr_vpn2), .wr_asid(wr_asid),
    .wr_mask(wr_mask), .wr_lo0(wr_lo0), .wr_lo1(wr_lo1),
    .rd_idx(rd_idx), .rd_vpn2(rd_vpn2), .rd_asid(rd_asid), .rd_mask(rd_mask),
    .rd_lo0(rd_lo0), .rd_lo1(rd_lo1),
    .lk_req(lk_req), .lk_va(lk_va), .lk_asid(lk_asid), .lk_kind(lk_kind),
    .lk_done(lk_done), .lk_fault(lk_fault), .lk_pa(lk_pa)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  function automatic logic [11:0] kmask(input int k);
    return 12'((1 << (2 * k)) - 1);
  endfunction

  task automatic wr(input int idx, input logic [31:0] vbase, input logic [7:0] asid,
                    input int k, input logic [31:0] lo0, input logic [31:0] lo1);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 4'(idx); wr_vpn2 = vbase[31:13]; wr_asid = asid;
    wr_mask = kmask(k); wr_lo0 = lo0; wr_lo1 = lo1;
    @(negedge clk);
    wr_en = 1'b0;
    m_vpn[idx] = vbase[31:13]; m_asid[idx] = asid; m_k[idx] = k;
    m_lo0[idx] = lo0; m_lo1[idx] = lo1;
  endtask

  task automatic model(input logic [31:0] va, input logic [7:0] asid, input logic [1:0] kind,
                       output logic [2:0] f, output logic [31:0] pa);
    int hit = -1;
    for (int i = 0; i < 16; i++) begin
      logic [31:0] base;
      int sh;
      base = {m_vpn[i], 13'b0};
      sh = 13 + 2 * m_k[i];
      if (hit < 0 && (va >> sh) == (base >> sh) && (m_asid[i] == asid || (m_lo0[i][0] & m_lo1[i][0])))
        hit = i;
    end
    pa = '0;
    if (hit < 0) f = 3'd1;
    else begin
      int hb;
      logic [31:0] lo;
      hb = 12 + 2 * m_k[hit];
      lo = va[hb] ? m_lo1[hit] : m_lo0[hit];
      f = 3'd0;
      if (!lo[1]) f = 3'd2;
      else if (kind == 2'd0 && lo[30]) f = 3'd5;
      else if (kind == 2'd1 && lo[31]) f = 3'd4;
      else if (kind == 2'd3 && lo[31] && lo[30]) f = 3'd4;
      else if (kind == 2'd2 && !lo[2]) f = 3'd3;
      if (f == 3'd0) pa = {lo[25:6], 12'b0} | (va & ((32'd1 << hb) - 32'd1));
    end
  endtask

  task automatic lk(input logic [31:0] va, input logic [7:0] asid, input logic [1:0] kind,
                    input logic [2:0] ef, input logic [31:0] epa, input string req);
    @(negedge clk);
    lk_req = 1'b1; lk_va = va; lk_asid = asid; lk_kind = kind;
    @(negedge clk);
    lk_req = 1'b0;
    chk(lk_done == 1'b1, req, 64'(lk_done), 64'd1);
    chk(lk_fault == ef, req, 64'(lk_fault), 64'(ef));
    chk(lk_pa == epa, req, 64'(lk_pa), 64'(epa));
  endtask

  task automatic lk_model(input logic [31:0] va, input logic [7:0] asid, input logic [1:0] kind,
                          input string req);
    logic [2:0] f;
    logic [31:0] pa;
    model(va, asid, kind, f, pa);
    lk(va, asid, kind, f, pa, req);
  endtask

  function automatic logic [31:0] img(input logic [31:0] lo, input bit g);
    return (lo & 32'hC3FF_FFFE) | 32'(g);
  endfunction

  task automatic rb(input int idx, input string req);
    bit g;
    @(negedge clk);
    rd_idx = 4'(idx);
    @(negedge clk);
    g = m_lo0[idx][0] & m_lo1[idx][0];
    chk(rd_vpn2 == m_vpn[idx], req, 64'(rd_vpn2), 64'(m_vpn[idx]));
    chk(rd_asid == m_asid[idx], req, 64'(rd_asid), 64'(m_asid[idx]));
    chk(rd_mask == kmask(m_k[idx]), req, 64'(rd_mask), 64'(kmask(m_k[idx])));
    chk(rd_lo0 == img(m_lo0[idx], g), req, 64'(rd_lo0), 64'(img(m_lo0[idx], g)));
    chk(rd_lo1 == img(m_lo1[idx], g), req, 64'(rd_lo1), 64'(img(m_lo1[idx], g)));
  endtask

  initial begin
    void'($urandom(32'd2718));
    for (int i = 0; i < 16; i++) begin
      m_vpn[i] = '0; m_asid[i] = '0; m_k[i] = 0; m_lo0[i] = '0; m_lo1[i] = '0;
    end
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R13: reset state
    chk(lk_done == 1'b0, "R13", 64'(lk_done), 64'd0);
    chk(lk_fault == 3'd0, "R13", 64'(lk_fault), 64'd0);
    chk(lk_pa == 32'd0, "R13", 64'(lk_pa), 64'd0);
    chk(rd_lo0 == 32'd0 && rd_lo1 == 32'd0, "R13", 64'(rd_lo0), 64'd0);
    lk(32'h0000_0000, 8'd0, 2'd0, 3'd2, 32'd0, "R13");
    lk(32'h5000_0000, 8'd0, 2'd1, 3'd1, 32'd0, "R13");

    // entry 0: even half read-inhibited, odd half execute-inhibited and clean
    wr(0, 32'h0040_0000, 8'd5, 0, 32'h8048_D146, 32'h4002_AF02);
    lk(32'h0040_0123, 8'd5, 2'd0, 3'd0, 32'h1234_5123, "R3 R5 fetch ignores RI");
    lk(32'h0040_0123, 8'd5, 2'd1, 3'd4, 32'd0, "R6 R9 load RI");
    lk(32'h0040_0123, 8'd5, 2'd3, 3'd0, 32'h1234_5123, "R7 pcload exempt");
    lk(32'h0040_0123, 8'd5, 2'd2, 3'd0, 32'h1234_5123, "R8 store ignores RI");
    lk(32'h0040_1010, 8'd5, 2'd0, 3'd5, 32'd0, "R2 R5 fetch XI odd");
    lk(32'h0040_1010, 8'd5, 2'd1, 3'd0, 32'h00AB_C010, "R6 load ignores XI");
    lk(32'h0040_1010, 8'd5, 2'd2, 3'd3, 32'd0, "R8 store clean");
    lk(32'h0040_1010, 8'd5, 2'd3, 3'd0, 32'h00AB_C010, "R7 pcload RI clear");
    lk(32'h0040_0123, 8'd6, 2'd0, 3'd1, 32'd0, "R1 asid mismatch");
    rb(0, "R11");

    // entry 1: global, even half invalid with every inhibit set
    wr(1, 32'h0080_0000, 8'd3, 0, 32'hC000_0001, 32'hC001_DDC3);
    lk(32'h0080_0044, 8'd9, 2'd0, 3'd2, 32'd0, "R4 invalid first");
    lk(32'h0080_0044, 8'd9, 2'd2, 3'd2, 32'd0, "R4 invalid before dirty");
    lk(32'h0080_1044, 8'd9, 2'd3, 3'd4, 32'd0, "R7 pcload RI and XI");
    lk(32'h0080_1044, 8'd9, 2'd0, 3'd5, 32'd0, "R1 R5 global hit");
    rb(1, "R10 R11");

    // entry 2: only one G bit set, so not global
    wr(2, 32'h00C0_0000, 8'd3, 0, 32'h0000_4007, 32'h0000_8006);
    lk(32'h00C0_0000, 8'd4, 2'd0, 3'd1, 32'd0, "R10 partial G");
    lk(32'h00C0_0abc, 8'd3, 2'd2, 3'd0, 32'h0010_0abc, "R3");
    rb(2, "R10");

    // entry 3: 16 MiB pages
    wr(3, 32'h0200_0000, 8'd1, 6, 32'h0010_0006, 32'h0014_0006);
    lk(32'h0212_3456, 8'd1, 2'd1, 3'd0, 32'h0412_3456, "R2 R14 big even");
    lk(32'h0312_3456, 8'd1, 2'd1, 3'd0, 32'h0512_3456, "R2 R14 big odd");
    lk(32'h0412_3456, 8'd1, 2'd1, 3'd1, 32'd0, "R1 R14 outside");
    rb(3, "R11 R14");

    // entries 4 and 5 overlap: lowest index wins (16 KiB pages)
    wr(5, 32'h0100_0000, 8'd2, 1, 32'h0002_4006, 32'h0);
    wr(4, 32'h0100_0000, 8'd2, 1, 32'h0000_C006, 32'h0);
    lk(32'h0100_2abc, 8'd2, 2'd1, 3'd0, 32'h0030_2abc, "R12 R14 lowest");
    lk(32'h0100_6abc, 8'd2, 2'd1, 3'd2, 32'd0, "R2 R14 16K odd");

    // random phase: every entry in its own region
    for (int i = 0; i < 16; i++) begin
      logic [31:0] base;
      base = {4'(i), 3'($urandom), 25'b0};
      wr(i, base, 8'(1 + $urandom % 4), int'($urandom % 7),
         $urandom & 32'hC3FF_FFFF, $urandom & 32'hC3FF_FFFF);
    end
    for (int i = 0; i < 16; i++) rb(i, "R11 random");
    for (int n = 0; n < 600; n++) begin
      logic [31:0] va;
      int j;
      j = int'($urandom % 16);
      if ($urandom % 5 == 0) va = $urandom;
      else va = {m_vpn[j], 13'b0} | ($urandom & ((32'd1 << (13 + 2 * m_k[j])) - 32'd1));
      lk_model(va, 8'(1 + $urandom % 4), 2'($urandom), "R1 R2 R3 R5 R6 R7 R8 random");
    end

    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule